// File: doc/BRIEF.md
# Predicated Rotated Complex Multiply-Accumulate Lane Unit

This unit treats each of its vector inputs as a row of complex numbers. Element `2p` holds the real part of pair `p` and element `2p+1` holds the imaginary part. For every pair it multiplies one component of the first source by the second source, rotated by 0, 90, 180 or 270 degrees. It then adds the two products into the matching pair of an accumulator vector. A two-bit rotation code picks which component of the first source is used, which components of the second source are used, and which products are subtracted rather than added. Two issues with the same operands and rotations 90 degrees apart (for example 0 then 90) build a full complex multiply-accumulate.

A per-element predicate decides which accumulator elements take the new value. Elements whose predicate is clear keep the accumulator value. Elements are signed two's-complement integers of 16, 32 or 64 bits, chosen per issue by a size code. Each element computes the exact product plus the accumulator, and the result keeps the low element-width bits. The reserved size code leaves the accumulator unchanged and raises an illegal flag. The result is registered and appears one cycle after the input strobe.

Top module: `cplx_rot_mac`

## Requirements
- R1: Pair `p` uses element `2p` as the real part and element `2p+1` as the imaginary part, for all three operands and for the result.
- R2: Rotation code 0 (0 degrees): real = acc_re + a_re*b_re, imag = acc_im + a_re*b_im.
- R3: Rotation code 1 (90 degrees): real = acc_re - a_im*b_im, imag = acc_im + a_im*b_re.
- R4: Rotation code 2 (180 degrees): real = acc_re - a_re*b_re, imag = acc_im - a_re*b_im.
- R5: Rotation code 3 (270 degrees): real = acc_re + a_im*b_im, imag = acc_im - a_im*b_re.
- R6: Element `j` of width `EW` is governed by predicate bit `j*EW/8`, which is the lowest byte bit of that element. A clear bit leaves that result element equal to the accumulator element. When no governing bit is set, the result equals the accumulator.
- R7: Size code 1, 2 and 3 select 16-, 32- and 64-bit elements, which gives 8, 4 and 2 pairs in a 256-bit vector.
- R8: Size code 0 makes the registered result equal to the accumulator input and sets `illegal`. A legal size code clears `illegal`.
- R9: Each result element is the low `EW` bits of the exact sum of the accumulator and the full product, so overflow wraps modulo 2^EW.
- R10: `out_valid` is high exactly in the cycle after an accepted `in_valid`. Without `in_valid`, `result` and `illegal` hold their values.
- R11: An issue with rotation 0 followed by an issue with rotation 1, where the second accumulator is the first result, gives acc + a*b as a full complex product in every pair.
- R12: After reset, `out_valid`, `illegal` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; captures the operation |
| size_code | input | 2 | Element size: 1=16, 2=32, 3=64 bits, 0 reserved |
| rot_code | input | 2 | Rotation: 0, 90, 180, 270 degrees |
| op_a | input | VEC_W | First source vector (duplicated component) |
| op_b | input | VEC_W | Second source vector (rotated) |
| acc_in | input | VEC_W | Accumulator vector |
| pred | input | VEC_W/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | VEC_W | Merged result vector |
| illegal | output | 1 | Reserved size code seen on the last issue |

## Verification
Every cycle, the assertions check the following:
- the one-cycle strobe timing;
- that result and flag hold between issues;
- that the reserved size copies the accumulator and raises the flag;
- that any predicated-off element equals its accumulator element inside each pair datapath.

Only the bench's scenarios can show the arithmetic itself. This covers the signs and component choices of each rotation at each element width, the predicate bit position per width, wrap-around at extreme values, and the two-issue full complex product.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef enum logic [1:0] {
    SZ_RSVD = 2'd0,
    SZ_H16  = 2'd1,
    SZ_W32  = 2'd2,
    SZ_D64  = 2'd3
  } elem_size_e;

  localparam int unsigned NUM_SIZES = 3;

  // element width in bits for bank index 0..2
  function automatic int unsigned bank_ew(input int unsigned idx);
    return 16 << idx;
  endfunction
endpackage

// File: rtl/crm_pair.sv
module crm_pair #(
  parameter int unsigned EW = 32
) (
  input  logic [EW-1:0] a_re,
  input  logic [EW-1:0] a_im,
  input  logic [EW-1:0] b_re,
  input  logic [EW-1:0] b_im,
  input  logic [EW-1:0] c_re,
  input  logic [EW-1:0] c_im,
  input  logic          act_re,
  input  logic          act_im,
  input  logic [1:0]    rot,
  output logic [EW-1:0] d_re,
  output logic [EW-1:0] d_im
);
  localparam int unsigned PW = 2 * EW;

  logic signed [EW-1:0] mul_a;
  logic signed [EW-1:0] bsel_re;
  logic signed [EW-1:0] bsel_im;
  logic signed [EW-1:0] bop_re;
  logic signed [EW-1:0] bop_im;
  logic signed [PW-1:0] prod_re;
  logic signed [PW-1:0] prod_im;
  logic signed [PW-1:0] sum_re;
  logic signed [PW-1:0] sum_im;
  logic                 neg_re;
  logic                 neg_im;

  always_comb begin
    // rot[0] picks the imaginary half of operand a and swaps operand b
    mul_a   = rot[0] ? a_im : a_re;
    bsel_re = rot[0] ? b_im : b_re;
    bsel_im = rot[0] ? b_re : b_im;
    neg_re  = rot[0] ^ rot[1];
    neg_im  = rot[1];
    bop_re  = neg_re ? -bsel_re : bsel_re;
    bop_im  = neg_im ? -bsel_im : bsel_im;
    prod_re = mul_a * bop_re;
    prod_im = mul_a * bop_im;
    sum_re  = $signed({{EW{c_re[EW-1]}}, c_re}) + prod_re;
    sum_im  = $signed({{EW{c_im[EW-1]}}, c_im}) + prod_im;
    d_re    = act_re ? sum_re[EW-1:0] : c_re;
    d_im    = act_im ? sum_im[EW-1:0] : c_im;
  end

  always_comb begin
    // R6
    inactive_re_keep_chk: assert (act_re || d_re == c_re);
    // R6
    inactive_im_keep_chk: assert (act_im || d_im == c_im);
  end
endmodule

// File: rtl/crm_bank.sv
module crm_bank #(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned EW    = 32
) (
  input  logic [VEC_W-1:0]   op_a,
  input  logic [VEC_W-1:0]   op_b,
  input  logic [VEC_W-1:0]   acc,
  input  logic [VEC_W/8-1:0] pred,
  input  logic [1:0]         rot,
  output logic [VEC_W-1:0]   res
);
  localparam int unsigned NP = VEC_W / (2 * EW);
  localparam int unsigned NE = 2 * NP;
  localparam int unsigned EB = EW / 8;

  logic [NE-1:0]    act;
  logic             any_act;
  logic [VEC_W-1:0] a_eff;
  logic [VEC_W-1:0] b_eff;
  logic             unused_pred;

  assign unused_pred = ^pred;

  for (genvar e = 0; e < NE; e++) begin : g_act
    assign act[e] = pred[e*EB];
  end

  assign any_act = |act;
  assign a_eff   = any_act ? op_a : '0;
  assign b_eff   = any_act ? op_b : '0;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    localparam int unsigned LO = 2 * p * EW;
    localparam int unsigned HI = LO + EW;
    crm_pair #(.EW(EW)) u_pair (
      .a_re  (a_eff[LO +: EW]),
      .a_im  (a_eff[HI +: EW]),
      .b_re  (b_eff[LO +: EW]),
      .b_im  (b_eff[HI +: EW]),
      .c_re  (acc[LO +: EW]),
      .c_im  (acc[HI +: EW]),
      .act_re(act[2*p]),
      .act_im(act[2*p+1]),
      .rot   (rot),
      .d_re  (res[LO +: EW]),
      .d_im  (res[HI +: EW])
    );
  end
endmodule

// File: rtl/cplx_rot_mac.sv
module cplx_rot_mac #(
  parameter int unsigned VEC_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         size_code,
  input  logic [1:0]         rot_code,
  input  logic [VEC_W-1:0]   op_a,
  input  logic [VEC_W-1:0]   op_b,
  input  logic [VEC_W-1:0]   acc_in,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               illegal
);
  import crm_pkg::*;

  logic [VEC_W-1:0] bank_res [NUM_SIZES];
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] res_d, res_q;
  logic             ill_d, ill_q;
  logic             vld_q;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
    crm_bank #(.VEC_W(VEC_W), .EW(bank_ew(g))) u_bank (
      .op_a(op_a),
      .op_b(op_b),
      .acc (acc_in),
      .pred(pred),
      .rot (rot_code),
      .res (bank_res[g])
    );
  end

  always_comb begin
    unique case (elem_size_e'(size_code))
      SZ_H16:  sel_res = bank_res[0];
      SZ_W32:  sel_res = bank_res[1];
      SZ_D64:  sel_res = bank_res[2];
      default: sel_res = acc_in;
    endcase
  end

  always_comb begin
    res_d = res_q;
    ill_d = ill_q;
    if (in_valid) begin
      res_d = sel_res;
      ill_d = (size_code == SZ_RSVD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        ill_q <= ill_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign illegal   = ill_q;

  // R10
  strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));
  // R8
  reserved_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd0) |=> (illegal && result == $past(acc_in)));
  // R8
  legal_size_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code != 2'd0) |=> !illegal);
endmodule

// File: tb/sim_cplx_rot_mac.sv
module sim_cplx_rot_mac;
  localparam int unsigned VW = 256;
  localparam int unsigned PW = VW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    size_code, rot_code;
  logic [VW-1:0] op_a, op_b, acc_in;
  logic [PW-1:0] pred;
  logic          out_valid, illegal;
  logic [VW-1:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cplx_rot_mac #(.VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .rot_code(rot_code), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .pred(pred), .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [63:0] msk(input int ew);
    return (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
  endfunction

  function automatic logic [63:0] getel(input logic [VW-1:0] v, input int j, input int ew);
    logic [VW-1:0] t;
    t = v >> (j * ew);
    return t[63:0] & msk(ew);
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // independent model of R1..R7, R9
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                          input logic [VW-1:0] c, input logic [PW-1:0] p,
                                          input logic [1:0] rot, input int ew);
    logic [VW-1:0] r;
    logic [63:0] ar, ai, br, bi, cr, ci, dr, di;
    bit any;
    int eb;
    eb = ew / 8;
    any = 1'b0;
    r = '0;
    for (int j = 0; j < VW / ew; j++) if (p[j*eb]) any = 1'b1;
    for (int q = 0; q < VW / (2 * ew); q++) begin
      ar = any ? getel(a, 2*q, ew) : 64'd0;
      ai = any ? getel(a, 2*q+1, ew) : 64'd0;
      br = any ? getel(b, 2*q, ew) : 64'd0;
      bi = any ? getel(b, 2*q+1, ew) : 64'd0;
      cr = getel(c, 2*q, ew);
      ci = getel(c, 2*q+1, ew);
      case (rot)
        2'd0: begin dr = cr + ar*br; di = ci + ar*bi; end
        2'd1: begin dr = cr - ai*bi; di = ci + ai*br; end
        2'd2: begin dr = cr - ar*br; di = ci - ar*bi; end
        default: begin dr = cr + ai*bi; di = ci - ai*br; end
      endcase
      if (!p[2*q*eb]) dr = cr;
      if (!p[(2*q+1)*eb]) di = ci;
      r = r | (VW'(dr & msk(ew)) << (2*q*ew));
      r = r | (VW'(di & msk(ew)) << ((2*q+1)*ew));
    end
    return r;
  endfunction

  function automatic int ew_of(input logic [1:0] sz);
    return 8 << sz;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one issue at a negedge, return after the result register updates
  task automatic issue(input logic [1:0] sz, input logic [1:0] rot, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic [VW-1:0] c, input logic [PW-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; size_code = sz; rot_code = rot;
    op_a = a; op_b = b; acc_in = c; pred = p;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 out_valid", VW'(out_valid), '0);
    chk("R12 illegal", VW'(illegal), '0);
    chk("R12 result", result, '0);
  endtask

  task automatic t_rotations();
    for (int sz = 1; sz < 4; sz++) begin
      for (int rot = 0; rot < 4; rot++) begin
        logic [VW-1:0] a, b, c;
        a = rand_vec(); b = rand_vec(); c = rand_vec();
        issue(2'(sz), 2'(rot), a, b, c, '1);
        chk($sformatf("R1 R7 rot%0d (R2/R3/R4/R5) size%0d", rot, sz), result,
            model(a, b, c, '1, 2'(rot), ew_of(2'(sz))));
      end
    end
  endtask

  task automatic t_small_values();
    logic [VW-1:0] a, b, c, e;
    // 32-bit, pair0: a=(3,5) b=(7,11) acc=(100,200); rot 1 -> (100-55, 200+35)
    a = '0; b = '0; c = '0;
    a[31:0] = 32'd3; a[63:32] = 32'd5;
    b[31:0] = 32'd7; b[63:32] = 32'd11;
    c[31:0] = 32'd100; c[63:32] = 32'd200;
    issue(2'd2, 2'd1, a, b, c, '1);
    e = '0; e[31:0] = 32'd45; e[63:32] = 32'd235;
    chk("R1 R3 pair layout", result, e);
  endtask

  task automatic t_predicate();
    for (int sz = 1; sz < 4; sz++) begin
      logic [VW-1:0] a, b, c;
      logic [PW-1:0] p;
      a = rand_vec(); b = rand_vec(); c = rand_vec(); p = PW'($urandom);
      issue(2'(sz), 2'd0, a, b, c, p);
      chk($sformatf("R6 merge size%0d", sz), result, model(a, b, c, p, 2'd0, ew_of(2'(sz))));
    end
    // only non-governing bits set for 64-bit elements: nothing active
    begin
      logic [VW-1:0] a, b, c;
      a = rand_vec(); b = rand_vec(); c = rand_vec();
      issue(2'd3, 2'd2, a, b, c, 32'hFEFE_FEFE);
      chk("R6 no governing bit", result, c);
      issue(2'd1, 2'd3, a, b, c, '0);
      chk("R6 empty predicate", result, c);
    end
  endtask

  task automatic t_reserved();
    logic [VW-1:0] a, b, c;
    a = rand_vec(); b = rand_vec(); c = rand_vec();
    issue(2'd0, 2'd0, a, b, c, '1);
    chk("R8 reserved result", result, c);
    chk("R8 illegal set", VW'(illegal), VW'(1));
    issue(2'd2, 2'd0, a, b, c, '1);
    chk("R8 illegal cleared", VW'(illegal), '0);
  endtask

  task automatic t_wrap();
    logic [VW-1:0] a, b, c, e;
    // 16-bit: a_re=0x7FFF, b_re=0x7FFF, acc=0x7FFF -> 0x7FFF + 0x3FFF0001 -> low 16 = 0x8000
    a = '0; b = '0; c = '0;
    a[15:0] = 16'h7FFF; b[15:0] = 16'h7FFF; c[15:0] = 16'h7FFF;
    issue(2'd1, 2'd0, a, b, c, '1);
    e = '0; e[15:0] = 16'h8000;
    chk("R9 wrap 16", result, e);
    // 64-bit min * -1 with random acc
    a = rand_vec(); b = rand_vec(); c = rand_vec();
    a[63:0] = 64'h8000_0000_0000_0000; b[63:0] = '1;
    issue(2'd3, 2'd2, a, b, c, '1);
    chk("R9 wrap 64", result, model(a, b, c, '1, 2'd2, 64));
  endtask

  task automatic t_timing();
    logic [VW-1:0] a, b, c, hold;
    a = rand_vec(); b = rand_vec(); c = rand_vec();
    @(negedge clk);
    in_valid = 1'b1; size_code = 2'd2; rot_code = 2'd3;
    op_a = a; op_b = b; acc_in = c; pred = '1;
    chk("R10 no early strobe", VW'(out_valid), '0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 strobe", VW'(out_valid), VW'(1));
    hold = result;
    op_a = rand_vec(); acc_in = rand_vec(); size_code = 2'd0;
    @(negedge clk);
    chk("R10 strobe drop", VW'(out_valid), '0);
    chk("R10 hold result", result, hold);
    chk("R10 hold illegal", VW'(illegal), '0);
  endtask

  task automatic t_full_cmul();
    logic [VW-1:0] a, b, c, mid, e;
    logic [31:0] ar, ai, br, bi;
    a = rand_vec(); b = rand_vec(); c = rand_vec();
    issue(2'd2, 2'd0, a, b, c, '1);
    mid = result;
    issue(2'd2, 2'd1, a, b, mid, '1);
    e = '0;
    for (int q = 0; q < 4; q++) begin
      ar = a[64*q +: 32]; ai = a[64*q+32 +: 32];
      br = b[64*q +: 32]; bi = b[64*q+32 +: 32];
      e[64*q +: 32]    = c[64*q +: 32] + ar*br - ai*bi;
      e[64*q+32 +: 32] = c[64*q+32 +: 32] + ar*bi + ai*br;
    end
    chk("R11 full complex product", result, e);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; size_code = '0; rot_code = '0;
    op_a = '0; op_b = '0; acc_in = '0; pred = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_values();
    t_rotations();
    t_predicate();
    t_reserved();
    t_wrap();
    t_timing();
    t_full_cmul();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule